// File: doc/BRIEF.md
# Parallel DAC Register Front End

This block is the digital side of a 12-bit converter fed from an 8-bit microcontroller bus. A host writes through a strobed parallel port. A 2-bit select steers each byte to one of three places: the low eight code bits, the upper four code bits, or a small control register. The two code pieces together form a 12-bit holding word. A second register, the output latch, copies that word and drives the analog side. It copies either through an active-low load pin or through a load-enable bit in the control register.

The load pin, the speed pin and the power pin are asynchronous. They, together with the whole bus, pass through synchroniser flops into the block clock. The strobe's rising edge becomes a single-cycle write event. Speed and power state are each formed from the pin and the register bit, and the two use opposite polarity rules. All outputs come from flops.

Top module: `dacfe_top`

## Requirements
- R1: A write is accepted only on a low-to-high transition of `wr_n` while `cs_n` is low; a strobe with `cs_n` high changes no stored value.
- R2: Select value 0 stores the whole data byte as code bits 7..0.
- R3: Select value 1 stores data bits 3..0 as code bits 11..8; data bits 7..4 of that byte are dropped.
- R4: Select value 2 is reserved: a write to it changes neither the code nor the control state.
- R5: Select value 3 writes the control register: data bit 0 is the speed bit (1 fast), bit 1 is the power bit (1 powered down), bit 2 is the load-enable bit (1 transparent); bits 7..3 are ignored.
- R6: The output latch follows the holding word while `load_n` is low or the load-enable bit is 1, and keeps its value while `load_n` is high and the bit is 0.
- R7: `fast_mode` is 1 when `speed_pin` is 1 or the speed bit is 1, and 0 only when both are 0.
- R8: `power_down` is 1 when `pwrdn_n` is low or the power bit is 1, and 0 only when the pin is high and the bit is 0.
- R9: Synchronous reset clears both holding parts, the control register and the output latch to zero.
- R10: Each input passes two synchroniser flops. A write that reaches a transparent latch shows on `dac_code` at the fourth rising clock edge, counting from the first edge that samples `wr_n` high. A pin change reaches `fast_mode` or `power_down` at the third such edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_data | input | 8 | Parallel data byte |
| bus_sel | input | 2 | Destination select |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe, captured on its rising edge |
| load_n | input | 1 | Active-low asynchronous output-latch load |
| speed_pin | input | 1 | Asynchronous speed request, 1 = fast |
| pwrdn_n | input | 1 | Active-low asynchronous power-down request |
| dac_code | output | 12 | Output latch value, {high nibble, low byte} |
| fast_mode | output | 1 | Resolved fast-settling mode |
| power_down | output | 1 | Resolved power-down state |

## Verification
The bench targets strobes made with chip select high and writes to the reserved select. A design that decoded these would show a changed code or changed flags after the next load. It writes a high byte with its top nibble set, which exposes a design that keeps the wrong bits. It drives the load pin and the load-enable bit one at a time. This catches a latch that ANDs the two instead of ORing them, or one that updates while held. It also sweeps each pin/bit combination of speed and power, where an inverted polarity shows at once. A behavioural model with the same latency is compared every clock, so one extra or missing pipeline stage is reported.

// File: rtl/dacfe_pkg.sv
`timescale 1ns/1ps
package dacfe_pkg;
  typedef enum logic [1:0] {
    SEL_LO   = 2'b00,
    SEL_HI   = 2'b01,
    SEL_RSV  = 2'b10,
    SEL_CTRL = 2'b11
  } sel_e;

  // control word bit order: [2] load enable, [1] power down, [0] fast
  typedef struct packed {
    logic ld_en;
    logic pd;
    logic fast;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/dacfe_sync.sv
`timescale 1ns/1ps
module dacfe_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= RST_VAL;
    else     chain[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= RST_VAL;
      else     chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dacfe_wrport.sv
`timescale 1ns/1ps
module dacfe_wrport
  import dacfe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HI_W = 4,
  localparam int CODE_W = DATA_W + HI_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] data_s,
  input  logic [1:0]        sel_s,
  input  logic              cs_n_s,
  input  logic              wr_n_s,
  output logic [CODE_W-1:0] hold_code,
  output ctrl_t             ctrl,
  output logic              wr_rise
);
  logic              wr_n_d;
  logic              wr_ok;
  logic [DATA_W-1:0] lo_q;
  logic [HI_W-1:0]   hi_q;

  always_ff @(posedge clk) begin
    if (rst) wr_n_d <= 1'b1;
    else     wr_n_d <= wr_n_s;
  end

  assign wr_rise = wr_n_s & ~wr_n_d;
  assign wr_ok   = wr_rise & ~cs_n_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
      ctrl <= '0;
    end else if (wr_ok) begin
      case (sel_s)
        SEL_LO:   lo_q <= data_s;
        SEL_HI:   hi_q <= data_s[HI_W-1:0];
        SEL_CTRL: ctrl <= ctrl_t'(data_s[CTRL_W-1:0]);
        default:  ;
      endcase
    end
  end

  assign hold_code = {hi_q, lo_q};
endmodule

// File: rtl/dacfe_outstage.sv
`timescale 1ns/1ps
module dacfe_outstage
  import dacfe_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] hold_code,
  input  ctrl_t             ctrl,
  input  logic              ld_n_s,
  input  logic              spd_s,
  input  logic              pwd_n_s,
  output logic [CODE_W-1:0] dac_code,
  output logic              fast_mode,
  output logic              power_down
);
  logic transparent;

  assign transparent = ~ld_n_s | ctrl.ld_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      dac_code   <= '0;
      fast_mode  <= 1'b0;
      power_down <= 1'b0;
    end else begin
      if (transparent) dac_code <= hold_code;
      fast_mode  <= spd_s | ctrl.fast;
      power_down <= ~pwd_n_s | ctrl.pd;
    end
  end
endmodule

// File: rtl/dacfe_top.sv
`timescale 1ns/1ps
module dacfe_top
  import dacfe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HI_W = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CODE_W = DATA_W + HI_W,
  localparam int BUS_W = DATA_W + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [1:0]        bus_sel,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              load_n,
  input  logic              speed_pin,
  input  logic              pwrdn_n,
  output logic [CODE_W-1:0] dac_code,
  output logic              fast_mode,
  output logic              power_down
);
  localparam logic [BUS_W-1:0] BUS_IDLE = {1'b1, 1'b1, 2'b00, {DATA_W{1'b0}}};

  logic [BUS_W-1:0]  bus_s;
  logic [2:0]        pin_s;
  logic [DATA_W-1:0] data_s;
  logic [1:0]        sel_s;
  logic              cs_n_s, wr_n_s;
  logic              ld_n_s, spd_s, pwd_n_s;
  logic [CODE_W-1:0] hold_code;
  ctrl_t             ctrl;
  logic              wr_rise;

  dacfe_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_IDLE)) u_bus_sync (
    .clk(clk), .rst(rst),
    .d({wr_n, cs_n, bus_sel, bus_data}),
    .q(bus_s)
  );

  dacfe_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b101)) u_pin_sync (
    .clk(clk), .rst(rst),
    .d({load_n, speed_pin, pwrdn_n}),
    .q(pin_s)
  );

  assign {wr_n_s, cs_n_s, sel_s, data_s} = bus_s;
  assign {ld_n_s, spd_s, pwd_n_s}        = pin_s;

  dacfe_wrport #(.DATA_W(DATA_W), .HI_W(HI_W)) u_wrport (
    .clk(clk), .rst(rst),
    .data_s(data_s), .sel_s(sel_s), .cs_n_s(cs_n_s), .wr_n_s(wr_n_s),
    .hold_code(hold_code), .ctrl(ctrl), .wr_rise(wr_rise)
  );

  dacfe_outstage #(.CODE_W(CODE_W)) u_out (
    .clk(clk), .rst(rst),
    .hold_code(hold_code), .ctrl(ctrl),
    .ld_n_s(ld_n_s), .spd_s(spd_s), .pwd_n_s(pwd_n_s),
    .dac_code(dac_code), .fast_mode(fast_mode), .power_down(power_down)
  );
endmodule

// File: rtl/dacfe_chk.sv
`timescale 1ns/1ps
module dacfe_chk #(
  parameter int DATA_W = 8,
  parameter int HI_W = 4,
  localparam int CODE_W = DATA_W + HI_W
) (
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] dac_code,
  input logic              fast_mode,
  input logic              power_down,
  input logic              ld_n_s,
  input logic              spd_s,
  input logic              pwd_n_s,
  input logic [2:0]        ctrl_bits,
  input logic [CODE_W-1:0] hold_code,
  input logic              wr_rise,
  input logic              cs_n_s,
  input logic [1:0]        sel_s,
  input logic [DATA_W-1:0] data_s
);
  // R1
  no_write_without_select_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_rise || cs_n_s) |=> ($stable(hold_code) && $stable(ctrl_bits)));

  // R4
  reserved_select_inert_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_rise && !cs_n_s && sel_s == 2'b10) |=> ($stable(hold_code) && $stable(ctrl_bits)));

  // R3
  high_nibble_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_rise && !cs_n_s && sel_s == 2'b01) |=> (hold_code[CODE_W-1:DATA_W] == $past(data_s[HI_W-1:0])));

  // R6
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_n_s && !ctrl_bits[2]) |=> $stable(dac_code));

  // R6
  latch_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld_n_s || ctrl_bits[2]) |=> (dac_code == $past(hold_code)));

  // R7
  fast_from_pin_chk: assert property (@(posedge clk) disable iff (rst)
    spd_s |=> fast_mode);

  // R7
  slow_when_both_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!spd_s && !ctrl_bits[0]) |=> !fast_mode);

  // R8
  powerdown_from_pin_chk: assert property (@(posedge clk) disable iff (rst)
    !pwd_n_s |=> power_down);

  // R8
  normal_when_both_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (pwd_n_s && !ctrl_bits[1]) |=> !power_down);
endmodule

bind dacfe_top dacfe_chk #(.DATA_W(DATA_W), .HI_W(HI_W)) u_chk (
  .clk(clk), .rst(rst),
  .dac_code(dac_code), .fast_mode(fast_mode), .power_down(power_down),
  .ld_n_s(ld_n_s), .spd_s(spd_s), .pwd_n_s(pwd_n_s),
  .ctrl_bits(ctrl), .hold_code(hold_code), .wr_rise(wr_rise),
  .cs_n_s(cs_n_s), .sel_s(sel_s), .data_s(data_s)
);

// File: tb/dacfe_top_test.sv
`timescale 1ns/1ps
module dacfe_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  d = 8'h00;
  logic [1:0]  a = 2'b00;
  logic        cs_n = 1'b1, wr_n = 1'b1;
  logic        ld_n = 1'b1, spd = 1'b0, pwd_n = 1'b1;
  logic [11:0] code;
  logic        fast, pd;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dacfe_top uut (
    .clk(clk), .rst(rst), .bus_data(d), .bus_sel(a), .cs_n(cs_n), .wr_n(wr_n),
    .load_n(ld_n), .speed_pin(spd), .pwrdn_n(pwd_n),
    .dac_code(code), .fast_mode(fast), .power_down(pd)
  );

  // Behavioural model: input history queues plus the architectural state.
  logic [11:0] bq[$];   // {wr_n, cs_n, sel, data}, newest first
  logic [2:0]  pq[$];   // {load_n, speed, pwrdn_n}, newest first
  logic [7:0]  m_lo;
  logic [3:0]  m_hi;
  logic [2:0]  m_ctrl;
  logic [11:0] m_dac;
  logic        m_fast, m_pd, m_valid = 1'b0;

  always @(posedge clk) begin
    logic [11:0] b2, b3, nd;
    logic [2:0]  p2;
    logic        nf, np;
    if (rst) begin
      m_lo = 0; m_hi = 0; m_ctrl = 0; m_dac = 0; m_fast = 0; m_pd = 0;
      bq = '{12'hC00, 12'hC00, 12'hC00};
      pq = '{3'b101, 3'b101};
    end else begin
      b2 = bq[1]; b3 = bq[2]; p2 = pq[1];
      nd = (!p2[2] || m_ctrl[2]) ? {m_hi, m_lo} : m_dac;
      nf = p2[1] | m_ctrl[0];
      np = !p2[0] | m_ctrl[1];
      if (b2[11] && !b3[11] && !b2[10]) begin
        if (b2[9:8] == 2'd0) m_lo = b2[7:0];
        else if (b2[9:8] == 2'd1) m_hi = b2[3:0];
        else if (b2[9:8] == 2'd3) m_ctrl = b2[2:0];
      end
      m_dac = nd; m_fast = nf; m_pd = np;
      bq.push_front({wr_n, cs_n, a, d}); void'(bq.pop_back());
      pq.push_front({ld_n, spd, pwd_n}); void'(pq.pop_back());
    end
    m_valid = 1'b1;
  end

  always @(negedge clk) begin
    if (m_valid) begin
      checks++;
      if (code !== m_dac || fast !== m_fast || pd !== m_pd) begin
        errors++;
        $display("FAIL R10 model compare: actual code=%h fast=%b pd=%b expected code=%h fast=%b pd=%b",
                 code, fast, pd, m_dac, m_fast, m_pd);
      end
    end
  end

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(input logic [1:0] sel, input logic [7:0] val, input logic sel_chip);
    @(negedge clk);
    cs_n = ~sel_chip; a = sel; d = val; wr_n = 1'b0;
    wait_n(2);
    wr_n = 1'b1;
    wait_n(5);
    cs_n = 1'b1;
    wait_n(1);
  endtask

  task automatic pulse_load();
    @(negedge clk); ld_n = 1'b0;
    wait_n(5);
    ld_n = 1'b1;
    wait_n(4);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_n(4);
    // R9 reset state
    chk("R9 code after reset", code, 12'h000);
    chk("R9 fast after reset", {11'd0, fast}, 12'd0);
    chk("R9 pd after reset", {11'd0, pd}, 12'd0);
    @(negedge clk) rst = 1'b0;
    wait_n(3);

    // R2 R3: fill holding word, R6 latch holds with pin high and bit 0
    put(2'd0, 8'hA5, 1'b1);
    put(2'd1, 8'h3C, 1'b1);
    chk("R6 hold while load_n high", code, 12'h000);
    pulse_load();
    chk("R2 R3 R6 load pin transfers", code, 12'hCA5);

    // R1 chip select high: ignored
    put(2'd0, 8'h11, 1'b0);
    pulse_load();
    chk("R1 strobe without select", code, 12'hCA5);

    // R4 reserved select
    put(2'd2, 8'hFF, 1'b1);
    pulse_load();
    chk("R4 reserved select code", code, 12'hCA5);
    chk("R4 reserved select flags", {10'd0, fast, pd}, 12'd0);

    // R5 upper control bits ignored
    put(2'd3, 8'hF8, 1'b1);
    chk("R5 bits 7..3 ignored flags", {10'd0, fast, pd}, 12'd0);
    put(2'd0, 8'h77, 1'b1);
    chk("R5 bits 7..3 ignored load", code, 12'hCA5);

    // R6 load-enable bit makes latch transparent; R10 latency
    put(2'd3, 8'h04, 1'b1);
    chk("R6 bit transparent", code, 12'hC77);
    @(negedge clk); cs_n = 1'b0; a = 2'd0; d = 8'h5A; wr_n = 1'b0;
    wait_n(2);
    wr_n = 1'b1;
    wait_n(3);
    chk("R10 code before fourth edge", code, 12'hC77);
    wait_n(1);
    chk("R10 code at fourth edge", code, 12'hC5A);
    wait_n(1); cs_n = 1'b1; wait_n(1);

    // R3 upper nibble of high byte discarded
    put(2'd1, 8'hF3, 1'b1);
    chk("R3 high byte upper bits dropped", code, 12'h35A);

    // R7 speed resolution
    put(2'd3, 8'h05, 1'b1);
    chk("R7 bit only fast", {11'd0, fast}, 12'd1);
    put(2'd3, 8'h04, 1'b1);
    chk("R7 both clear slow", {11'd0, fast}, 12'd0);
    @(negedge clk) spd = 1'b1;
    wait_n(2);
    chk("R10 fast before third edge", {11'd0, fast}, 12'd0);
    wait_n(1);
    chk("R7 R10 pin only fast", {11'd0, fast}, 12'd1);
    put(2'd3, 8'h05, 1'b1);
    chk("R7 pin and bit fast", {11'd0, fast}, 12'd1);
    @(negedge clk) spd = 1'b0;
    put(2'd3, 8'h04, 1'b1);
    chk("R7 cleared again", {11'd0, fast}, 12'd0);

    // R8 power resolution
    put(2'd3, 8'h06, 1'b1);
    chk("R8 bit only down", {11'd0, pd}, 12'd1);
    put(2'd3, 8'h04, 1'b1);
    chk("R8 both normal", {11'd0, pd}, 12'd0);
    @(negedge clk) pwd_n = 1'b0;
    wait_n(4);
    chk("R8 pin only down", {11'd0, pd}, 12'd1);
    @(negedge clk) pwd_n = 1'b1;
    wait_n(4);
    chk("R8 pin released", {11'd0, pd}, 12'd0);

    // R9 reset mid-run clears everything
    put(2'd3, 8'h07, 1'b1);
    @(negedge clk) rst = 1'b1;
    wait_n(3);
    chk("R9 code cleared", code, 12'h000);
    @(negedge clk) rst = 1'b0;
    wait_n(4);
    chk("R9 control cleared", {10'd0, fast, pd}, 12'd0);
    pulse_load();
    chk("R9 holding cleared", code, 12'h000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule